// File: doc/BRIEF.md
# Indirect Interrupt Redirection Controller

This block takes a bank of level-sensitive interrupt lines and turns each new assertion into a message write. The message carries a 6-bit vector, and its target address comes from the line's own entry. Every line owns two 32-bit words. The low word holds control flags and the vector. The destination word holds the target address in a packed form. Software never addresses these words directly. It first writes an index into a select register, then reads or writes a window register that reaches the word named by that index.

A pending vector (one bit per slot, slot = vector modulo the line count) keeps a second message for the same slot from going out while the first is still outstanding. Software retires a slot by writing its vector to an end-of-interrupt register. A line that falls also releases its slot. Owed messages leave one per handshake, lowest line first.

Top module: `irq_redirect`

## Requirements
- R1: With select index 0x01, a window read at offset 0x810 returns the identification word (NUM_LINES << 16) | 1, which is 0x00200001 for 32 lines. Window writes at that index change nothing. A read at offset 0x800 returns the select index last written.
- R2: Line i's low word is at index 0x10+2*i and its destination word is at 0x11+2*i. A window write stores all 32 bits, and a window read returns them unchanged.
- R3: After reset, line i's low word is 0x0001A000 | ((i+2) mod 64). In that word bit 16 is the mask, bit 15 is level, bit 13 is active-low and bits [5:0] are the vector. Every destination word is the packed form of the default target 0xFFFB0000, which is 0xB0FF0000. No message is offered.
- R4: Window reads at indices 0x00, 0x02 to 0x0F, and anything above the last line's destination word (0x4F for 32 lines) return zero. Window writes there are ignored.
- R5: A rising line whose low word has bit 16 clear and whose destination word is non-zero sets pending slot (vector mod 32) and asks for one message. The request is visible the cycle after the edge. msg_data_o is the vector zero-extended. msg_addr_o is {32'hFFFFFFFF, ((d<<4)&0x0FF00000) | ((d>>12)&0x000FF000) | 0xF0000000}, where d is the destination word.
- R6: A rising line that is masked (bit 16 set) or has an all-zero destination word sends no message.
- R7: A line that rises while its slot is already pending sends no message.
- R8: A write to offset 0x840 takes bits [5:0] of the data as a vector and clears the pending slot of every line whose vector equals it. A non-matching vector leaves the slot set.
- R9: Owed messages are offered in ascending line order, one per cycle in which msg_valid_o and msg_ready_i are both high. While msg_ready_i is low the request stays up.
- R10: A falling line, or a rising line that is masked or has a zero destination, clears its pending slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 12 | Register offset (0x800 select, 0x810 window, 0x840 end-of-interrupt) |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_i | input | NUM_LINES | Interrupt lines, level sensitive |
| msg_valid_o | output | 1 | Message write request |
| msg_ready_i | input | 1 | Message accepted this cycle |
| msg_addr_o | output | 64 | Message target address |
| msg_data_o | output | 32 | Message payload (vector) |

## Verification
The hardest case to reach is a slot that is already pending when a second line rises. That line has to be suppressed, and later it has to be released by either an end-of-interrupt write or the first line falling. To build this case, the stimulus programs several lines with the same vector and keeps one of them high. It then sends one end-of-interrupt with a vector that does not match and one with a vector that does, with extra high-order bits set in the data. Ordering is checked by raising three unmasked lines in the same cycle while msg_ready_i is held low, and then draining them one handshake at a time.

// File: rtl/irq_redirect_pkg.sv
package irq_redirect_pkg;

  localparam logic [11:0] OFS_SEL = 12'h800;
  localparam logic [11:0] OFS_WIN = 12'h810;
  localparam logic [11:0] OFS_EOI = 12'h840;

  localparam int ENTRY_BASE = 16;
  localparam int ID_INDEX   = 1;
  localparam int VEC_W      = 6;

  localparam int MASK_BIT   = 16;
  localparam int LEVEL_BIT  = 15;
  localparam int POL_BIT    = 13;
  localparam int LOWPRI_BIT = 8;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_SEL,
    ACC_WIN,
    ACC_EOI
  } acc_e;

  function automatic logic [31:0] pack_dest(input logic [31:0] a);
    return ((a & 32'h0FF0_0000) >> 4) | ((a & 32'h000F_F000) << 12);
  endfunction

  function automatic logic [31:0] unpack_dest(input logic [31:0] d);
    return ((d << 4) & 32'h0FF0_0000) | ((d >> 12) & 32'h000F_F000) | 32'hF000_0000;
  endfunction

endpackage

// File: rtl/irq_redirect_regs.sv
module irq_redirect_regs
  import irq_redirect_pkg::*;
#(
  parameter int          NUM_LINES    = 32,
  parameter int          SEL_W        = 8,
  parameter logic [31:0] DEF_CPU_ADDR = 32'hFFFB_0000,
  parameter int          VEC_BASE     = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  acc_e                                 acc_i,
  input  logic                                 we_i,
  input  logic [31:0]                          wdata_i,
  output logic [31:0]                          rdata_o,
  output logic [SEL_W-1:0]                     sel_o,
  output logic [NUM_LINES-1:0][VEC_W-1:0]      vec_o,
  output logic [NUM_LINES-1:0]                 masked_o,
  output logic [NUM_LINES-1:0]                 live_o,
  output logic [NUM_LINES-1:0][31:0]           phys_o
);

  localparam logic [31:0] ID_WORD  = 32'((NUM_LINES << 16) | 1);
  localparam logic [31:0] DEF_DEST = pack_dest(DEF_CPU_ADDR);

  logic [SEL_W-1:0]             sel_q;
  logic [NUM_LINES-1:0][31:0]   low_q;
  logic [NUM_LINES-1:0][31:0]   dest_q;
  logic                         win_wr;

  assign win_wr = we_i && (acc_i == ACC_WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sel_q <= '0;
    else if (we_i && (acc_i == ACC_SEL))  sel_q <= wdata_i[SEL_W-1:0];
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
    localparam logic [31:0] DEF_LOW = (32'd1 << MASK_BIT) | (32'd1 << LEVEL_BIT) |
                                      (32'd1 << POL_BIT) | 32'((g + VEC_BASE) % 64);
    localparam logic [SEL_W-1:0] LOW_IDX  = SEL_W'(ENTRY_BASE + 2 * g);
    localparam logic [SEL_W-1:0] DEST_IDX = SEL_W'(ENTRY_BASE + 2 * g + 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        low_q[g]  <= DEF_LOW;
        dest_q[g] <= DEF_DEST;
      end else if (win_wr) begin
        if (sel_q == LOW_IDX)  low_q[g]  <= wdata_i;
        if (sel_q == DEST_IDX) dest_q[g] <= wdata_i;
      end
    end

    assign vec_o[g]    = low_q[g][VEC_W-1:0];
    assign masked_o[g] = low_q[g][MASK_BIT];
    assign live_o[g]   = |dest_q[g];
    assign phys_o[g]   = unpack_dest(dest_q[g]);
  end

  logic [31:0] win_rd;
  always_comb begin
    win_rd = '0;
    if (sel_q == SEL_W'(ID_INDEX)) win_rd = ID_WORD;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (sel_q == SEL_W'(ENTRY_BASE + 2 * i))     win_rd = low_q[i];
      if (sel_q == SEL_W'(ENTRY_BASE + 2 * i + 1)) win_rd = dest_q[i];
    end
  end

  always_comb begin
    unique case (acc_i)
      ACC_SEL: rdata_o = 32'(sel_q);
      ACC_WIN: rdata_o = win_rd;
      default: rdata_o = '0;
    endcase
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/irq_redirect_pend.sv
module irq_redirect_pend
  import irq_redirect_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LINES-1:0]             irq_i,
  input  logic [NUM_LINES-1:0][VEC_W-1:0]  vec_i,
  input  logic [NUM_LINES-1:0]             masked_i,
  input  logic [NUM_LINES-1:0]             live_i,
  input  logic                             eoi_i,
  input  logic [VEC_W-1:0]                 eoi_vec_i,
  input  logic                             take_i,
  input  logic [LINE_W-1:0]                take_line_i,
  output logic [NUM_LINES-1:0]             owe_o
);

  localparam int SLOTS = 1 << LINE_W;

  logic [NUM_LINES-1:0] irq_q, owe_q, owe_n;
  logic [SLOTS-1:0]     slot_q, slot_n;

  always_comb begin
    slot_n = slot_q;
    owe_n  = owe_q;
    if (take_i) owe_n[take_line_i] = 1'b0;
    // retire before new edges in the same cycle
    if (eoi_i) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (vec_i[i] == eoi_vec_i) slot_n[vec_i[i][LINE_W-1:0]] = 1'b0;
    end
    for (int i = 0; i < NUM_LINES; i++) begin
      if (irq_i[i] && !irq_q[i] && !masked_i[i] && live_i[i]) begin
        if (!slot_n[vec_i[i][LINE_W-1:0]]) owe_n[i] = 1'b1;
        slot_n[vec_i[i][LINE_W-1:0]] = 1'b1;
      end else if (irq_i[i] != irq_q[i]) begin
        slot_n[vec_i[i][LINE_W-1:0]] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      owe_q  <= '0;
      slot_q <= '0;
    end else begin
      irq_q  <= irq_i;
      owe_q  <= owe_n;
      slot_q <= slot_n;
    end
  end

  assign owe_o = owe_q;

endmodule

// File: rtl/irq_redirect_arb.sv
module irq_redirect_arb
  import irq_redirect_pkg::*;
#(
  parameter int NUM_LINES = 32,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0]             owe_i,
  input  logic [NUM_LINES-1:0][VEC_W-1:0]  vec_i,
  input  logic [NUM_LINES-1:0][31:0]       phys_i,
  input  logic                             msg_ready_i,
  output logic                             msg_valid_o,
  output logic [63:0]                      msg_addr_o,
  output logic [31:0]                      msg_data_o,
  output logic                             take_o,
  output logic [LINE_W-1:0]                take_line_o
);

  logic [LINE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (owe_i[i]) pick = LINE_W'(i);
  end

  assign msg_valid_o = |owe_i;
  assign msg_addr_o  = {32'hFFFF_FFFF, phys_i[pick]};
  assign msg_data_o  = 32'(vec_i[pick]);
  assign take_o      = msg_valid_o && msg_ready_i;
  assign take_line_o = pick;

endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irq_redirect_pkg::*;
#(
  parameter int          NUM_LINES    = 32,
  parameter int          SEL_W        = 8,
  parameter logic [31:0] DEF_CPU_ADDR = 32'hFFFB_0000,
  parameter int          VEC_BASE     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [11:0]          reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic                 msg_valid_o,
  input  logic                 msg_ready_i,
  output logic [63:0]          msg_addr_o,
  output logic [31:0]          msg_data_o
);

  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  acc_e                             acc;
  logic [SEL_W-1:0]                 sel_idx;
  logic [NUM_LINES-1:0][VEC_W-1:0]  vec;
  logic [NUM_LINES-1:0]             masked, live, owe;
  logic [NUM_LINES-1:0][31:0]       phys;
  logic                             take;
  logic [LINE_W-1:0]                take_line;

  always_comb begin
    unique case (reg_addr_i)
      OFS_SEL: acc = ACC_SEL;
      OFS_WIN: acc = ACC_WIN;
      OFS_EOI: acc = ACC_EOI;
      default: acc = ACC_NONE;
    endcase
  end

  irq_redirect_regs #(
    .NUM_LINES(NUM_LINES), .SEL_W(SEL_W),
    .DEF_CPU_ADDR(DEF_CPU_ADDR), .VEC_BASE(VEC_BASE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .we_i(reg_we_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .sel_o(sel_idx),
    .vec_o(vec), .masked_o(masked), .live_o(live), .phys_o(phys)
  );

  irq_redirect_pend #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .vec_i(vec),
    .masked_i(masked), .live_i(live),
    .eoi_i(reg_we_i && (acc == ACC_EOI)), .eoi_vec_i(reg_wdata_i[VEC_W-1:0]),
    .take_i(take), .take_line_i(take_line), .owe_o(owe)
  );

  irq_redirect_arb #(.NUM_LINES(NUM_LINES)) u_arb (
    .owe_i(owe), .vec_i(vec), .phys_i(phys), .msg_ready_i(msg_ready_i),
    .msg_valid_o(msg_valid_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
    .take_o(take), .take_line_o(take_line)
  );

endmodule

// File: rtl/irq_redirect_chk.sv
module irq_redirect_chk
  import irq_redirect_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int SEL_W     = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [11:0]      reg_addr_i,
  input logic [31:0]      reg_rdata_o,
  input logic [SEL_W-1:0] sel_idx,
  input logic             msg_valid_o,
  input logic             msg_ready_i,
  input logic [63:0]      msg_addr_o,
  input logic [31:0]      msg_data_o
);

  localparam int          LAST_IDX = ENTRY_BASE + 2 * NUM_LINES - 1;
  localparam logic [31:0] ID_WORD  = 32'((NUM_LINES << 16) | 1);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o);

  p_addr_fmt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_addr_o[63:28] == {36{1'b1}}) && (msg_addr_o[11:0] == 12'h0));

  p_data_fmt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_data_o[31:VEC_W] == '0);

  p_id_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFS_WIN) && (sel_idx == SEL_W'(ID_INDEX)) |-> reg_rdata_o == ID_WORD);

  p_out_of_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == OFS_WIN) && (int'(sel_idx) > LAST_IDX) |-> reg_rdata_o == '0);

endmodule

bind irq_redirect irq_redirect_chk #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o),
  .sel_idx(sel_idx), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
  .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
);

// File: tb/irq_redirect_tb.sv
module irq_redirect_tb;

  localparam int N = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [11:0]   reg_addr_i = '0;
  logic          reg_we_i = 1'b0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [N-1:0]  irq_i = '0;
  logic          msg_valid_o;
  logic          msg_ready_i = 1'b0;
  logic [63:0]   msg_addr_o;
  logic [31:0]   msg_data_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  irq_redirect u_dut (.*);

  // {index, write data, expected read}
  localparam logic [71:0] TBL [0:6] = '{
    {8'h10, 32'h0001_2345, 32'h0001_2345},
    {8'h11, 32'hA0FF_0000, 32'hA0FF_0000},
    {8'h4F, 32'h0000_DEAD, 32'h0000_DEAD},
    {8'h50, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h05, 32'h0000_0001, 32'h0000_0000},
    {8'h01, 32'h0000_0007, 32'h0020_0001},
    {8'hFF, 32'h0000_0001, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
    wr(12'h800, 32'(idx));
    wr(12'h810, d);
  endtask

  task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
    wr(12'h800, 32'(idx));
    reg_addr_i = 12'h810;
    #1 d = reg_rdata_o;
  endtask

  task automatic set_line(input int line, input logic v);
    @(negedge clk_i);
    irq_i[line] = v;
    @(negedge clk_i);
  endtask

  task automatic accept();
    @(negedge clk_i);
    msg_ready_i = 1'b1;
    @(negedge clk_i);
    msg_ready_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    irq_i = '0;
    msg_ready_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R3 reset state
    check("R3 no message after reset", 64'(msg_valid_o), 64'd0);
    win_rd(8'h10, d); check("R3 line 0 low word", 64'(d), 64'h0001_A002);
    win_rd(8'h11, d); check("R3 line 0 destination", 64'(d), 64'hB0FF_0000);
    win_rd(8'h4E, d); check("R3 line 31 low word", 64'(d), 64'h0001_A021);
    reg_addr_i = 12'h800;
    #1 check("R1 select readback", 64'(reg_rdata_o), 64'h4E);

    // window table: R1, R2, R4
    for (int k = 0; k < 7; k++) begin
      logic [7:0]  idx;
      logic [31:0] wd, ex;
      {idx, wd, ex} = TBL[k];
      win_wr(idx, wd);
      win_rd(idx, d);
      if (idx == 8'h01)      check("R1 id word", 64'(d), 64'(ex));
      else if (ex == wd)     check("R2 window store", 64'(d), 64'(ex));
      else                   check("R4 unimplemented index", 64'(d), 64'(ex));
    end

    do_reset();

    // R5: line 3, vector 5, default destination
    win_wr(8'h16, 32'h0000_A005);
    win_wr(8'h18, 32'h0000_A005);
    win_wr(8'h1A, 32'h0000_A005);
    set_line(3, 1'b1);
    check("R5 valid on rise", 64'(msg_valid_o), 64'd1);
    check("R5 vector data", 64'(msg_data_o), 64'd5);
    check("R5 address", msg_addr_o, 64'hFFFF_FFFF_FFFB_0000);
    accept();
    check("R9 drained after accept", 64'(msg_valid_o), 64'd0);

    // R8 non-matching EOI keeps slot; R7 duplicate suppressed
    wr(12'h840, 32'h0000_0046);
    set_line(4, 1'b1);
    check("R7 R8 shared slot no message", 64'(msg_valid_o), 64'd0);
    // R10: falling releases slot
    set_line(4, 1'b0);
    set_line(4, 1'b1);
    check("R10 re-rise after fall sends", 64'(msg_valid_o), 64'd1);
    accept();
    // R8 matching EOI (upper bits ignored)
    wr(12'h840, 32'h0000_0045);
    set_line(5, 1'b1);
    check("R8 EOI releases slot", 64'(msg_valid_o), 64'd1);
    check("R8 vector", 64'(msg_data_o), 64'd5);
    accept();
    irq_i[3] = 1'b0; irq_i[4] = 1'b0; irq_i[5] = 1'b0;

    // R6: masked line 6, zero destination line 7
    set_line(6, 1'b1);
    check("R6 masked line silent", 64'(msg_valid_o), 64'd0);
    win_wr(8'h1E, 32'h0000_A007);
    win_wr(8'h1F, 32'h0000_0000);
    set_line(7, 1'b1);
    check("R6 zero destination silent", 64'(msg_valid_o), 64'd0);

    // R5 other destination and vector
    win_wr(8'h20, 32'h0000_A02A);
    win_wr(8'h21, 32'h1234_0000);
    set_line(8, 1'b1);
    check("R5 vector 0x2A", 64'(msg_data_o), 64'h2A);
    check("R5 unpacked address", msg_addr_o, 64'hFFFF_FFFF_F341_2000);
    accept();

    // R9 ordering
    win_wr(8'h22, 32'h0000_A014);
    win_wr(8'h28, 32'h0000_A015);
    win_wr(8'h38, 32'h0000_A016);
    @(negedge clk_i);
    irq_i[9] = 1'b1; irq_i[12] = 1'b1; irq_i[20] = 1'b1;
    @(negedge clk_i);
    check("R9 first is lowest line", 64'(msg_data_o), 64'd20);
    @(negedge clk_i);
    check("R9 held while not ready", 64'(msg_data_o), 64'd20);
    check("R9 valid held", 64'(msg_valid_o), 64'd1);
    msg_ready_i = 1'b1;
    @(negedge clk_i);
    check("R9 second", 64'(msg_data_o), 64'd21);
    @(negedge clk_i);
    check("R9 third", 64'(msg_data_o), 64'd22);
    @(negedge clk_i);
    check("R9 all drained", 64'(msg_valid_o), 64'd0);
    msg_ready_i = 1'b0;

    finish_run();
  end

endmodule